// File: doc/BRIEF.md
# Pin-Change Edge Interrupt Unit

This block raises an interrupt request when selected pins of one 8-bit general-purpose port see an edge. Only four positions of that port are live for this purpose: bits 7, 6, 1 and 0. Each live pin is passed through a two-flop synchroniser. Its synchronised value is then compared with the value from the previous cycle. A per-pin polarity vector, owned by a neighbouring port register, picks the edge direction for that pin.

A detected edge sets a sticky pending flag. The flag latches whether or not the pin's interrupt is enabled, so the enable register only masks the request. Software clears a flag by writing a 1 to its bit. A single registered request line is high while any flag and its matching enable are both set.

Two byte-wide registers hold the enables and the flags. They sit on a plain register bus with a select, a write strobe, an address and write data. Read data is driven combinationally from the address. This is a control and status block with no streaming data path, so the bus has no valid/ready handshake and never applies back-pressure: every access completes in the cycle it is presented.

Top module: `pcirq_unit`

## Requirements
- R1: While reset is asserted, and at its release, the enable register, the flag register and `irq_o` are all 0.
- R2: The enable register reads at address 0x2E and the flag register at 0x2F. Any other address reads 0x00. Bit positions 5 to 2 of both registers always read 0, and writes to those positions are ignored. The live positions are 7, 6, 1 and 0 (mask 0xC3).
- R3: A write with `bus_sel`=1 and `bus_wr`=1 to 0x2E stores `bus_wdata & 0xC3` into the enable register at that clock edge. Both registers can be read at any time. A write to the enable register never changes any flag.
- R4: When `pol_i` bit n is 1, a rising edge on live pin n sets flag n. When it is 0, a falling edge sets flag n. An edge in the other direction leaves the flag unchanged. A level change that is first present at a rising clock edge is visible in the flag register after the third rising edge, counting that one.
- R5: Writing a 1 to a live bit at 0x2F clears that flag at the write edge. Writing a 0 leaves the flag unchanged.
- R6: If an active edge is detected on a bit in the same cycle that a write-one clear hits that bit, the flag ends up set.
- R7: `irq_o` is registered. At each clock edge it takes the OR, over the live bits, of flag AND enable as they stood before that edge. Flags latch while their enable is 0 and raise no request until enabled.
- R8: No flag is set by a pin level already present during reset, and a change on pins 5 to 2 never sets any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Asynchronous port pin levels |
| pol_i | input | 8 | Edge select per pin: 1 rising, 0 falling |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 6 | Register address within the module |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The bench targets a write-one clear landing on the same edge that the synchroniser delivers an edge. A design that lets the clear win would silently drop that event. Pins held high through reset are another target, since a design that does not prime its edge history would flag a phantom rising edge right after reset. The bench also drives edges in the direction opposite to the polarity bit, and drives changes on the reserved pins; a decoder that ignores the polarity or the live mask would set flags there. Finally, the bench checks the exact cycle in which `irq_o` rises after an enable write. This catches a request that is combinational, or one that is delayed by an extra register.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int unsigned PORT_W      = 8;
  localparam int unsigned ADDR_W      = 6;
  localparam logic [7:0]  LIVE_BITS   = 8'hC3;
  localparam logic [5:0]  ADDR_ENABLE = 6'h2E;
  localparam logic [5:0]  ADDR_FLAGS  = 6'h2F;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_EN    = 2'd1,
    SEL_FLAG  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/pcirq_edge.sv
module pcirq_edge #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] LIVE   = 8'hC3,
  parameter int unsigned ARM_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o
);
  localparam int unsigned CW = $clog2(ARM_CYC + 1);
  localparam logic [CW-1:0] ARM_VAL = CW'(ARM_CYC);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] arm_cnt_q;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      arm_cnt_q <= '0;
    end else begin
      prev_q <= level_i;
      if (arm_cnt_q != ARM_VAL) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  assign armed = (arm_cnt_q == ARM_VAL);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic rise, fall;
      assign rise     = level_i[i] & ~prev_q[i];
      assign fall     = ~level_i[i] & prev_q[i];
      assign hit_o[i] = armed & (pol_i[i] ? rise : fall);
    end else begin : g_dead
      assign hit_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pcirq_regs.sv
module pcirq_regs #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] LIVE = 8'hC3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic         wr_flag_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hit_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] flag_o,
  output logic         irq_o
);
  logic [W-1:0] en_q, flag_q, clr_mask, flag_nxt;
  logic         irq_q;

  assign clr_mask = wr_flag_i ? (wdata_i & LIVE) : '0;
  assign flag_nxt = (flag_q & ~clr_mask) | (hit_i & LIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i) en_q <= wdata_i & LIVE;
      flag_q <= flag_nxt;
      irq_q  <= |(flag_q & en_q & LIVE);
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/pcirq_unit.sv
module pcirq_unit
  import pcirq_pkg::*;
#(
  parameter int unsigned PORT_W_P    = PORT_W,
  parameter int unsigned ADDR_W_P    = ADDR_W,
  parameter logic [PORT_W_P-1:0] LIVE_MASK = LIVE_BITS,
  parameter logic [ADDR_W_P-1:0] EN_ADDR   = ADDR_ENABLE,
  parameter logic [ADDR_W_P-1:0] FLAG_ADDR = ADDR_FLAGS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PORT_W_P-1:0] pins_i,
  input  logic [PORT_W_P-1:0] pol_i,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W_P-1:0] bus_addr,
  input  logic [PORT_W_P-1:0] bus_wdata,
  output logic [PORT_W_P-1:0] bus_rdata,
  output logic                irq_o
);
  localparam int unsigned ARM_CYC = SYNC_STAGES + 1;

  reg_sel_e            rsel;
  logic                wr_en_s, wr_flag_s;
  logic [PORT_W_P-1:0] level_s, edge_hit, en_q, flag_q;

  always_comb begin
    if (bus_addr == EN_ADDR)        rsel = SEL_EN;
    else if (bus_addr == FLAG_ADDR) rsel = SEL_FLAG;
    else                            rsel = SEL_NONE;
  end

  assign wr_en_s   = bus_sel & bus_wr & (rsel == SEL_EN);
  assign wr_flag_s = bus_sel & bus_wr & (rsel == SEL_FLAG);

  pcirq_sync #(.W(PORT_W_P), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(level_s)
  );

  pcirq_edge #(.W(PORT_W_P), .LIVE(LIVE_MASK), .ARM_CYC(ARM_CYC)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(level_s), .pol_i(pol_i), .hit_o(edge_hit)
  );

  pcirq_regs #(.W(PORT_W_P), .LIVE(LIVE_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_s), .wr_flag_i(wr_flag_s),
    .wdata_i(bus_wdata), .hit_i(edge_hit), .en_o(en_q), .flag_o(flag_q),
    .irq_o(irq_o)
  );

  always_comb begin
    unique case (rsel)
      SEL_EN:   bus_rdata = en_q & LIVE_MASK;
      SEL_FLAG: bus_rdata = flag_q & LIVE_MASK;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcirq_unit_chk.sv
module pcirq_unit_chk #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] LIVE = 8'hC3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en_s,
  input logic         wr_flag_s,
  input logic [W-1:0] wdata,
  input logic [W-1:0] hit,
  input logic [W-1:0] en_q,
  input logic [W-1:0] flag_q,
  input logic [W-1:0] rdata,
  input logic         irq_o
);
  // R2: reserved positions never read as 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~LIVE) == '0);

  // R3: enable write stores masked data
  a_r3_enable_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_s |=> en_q == $past(wdata & LIVE));

  // R3: enable write leaves flags alone
  a_r3_flags_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_s && !wr_flag_s && hit == '0) |=> $stable(flag_q));

  // R5: write-one clears bits with no concurrent edge
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag_s |=> (flag_q & $past(wdata & LIVE & ~hit)) == '0);

  // R6: a detected edge always leaves its flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (flag_q & $past(hit)) == $past(hit));

  // R7: request follows masked flags one cycle later
  a_r7_irq_reg: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == (|($past(flag_q & en_q))));

  // R8: a flag only rises when an edge was detected
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q & ~$past(flag_q) & ~$past(hit)) == '0);
endmodule

bind pcirq_unit pcirq_unit_chk #(.W(PORT_W_P), .LIVE(LIVE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_s(wr_en_s), .wr_flag_s(wr_flag_s),
  .wdata(bus_wdata), .hit(edge_hit), .en_q(en_q), .flag_q(flag_q),
  .rdata(bus_rdata), .irq_o(irq_o)
);

// File: tb/pcirq_unit_test.sv
module pcirq_unit_test;
  localparam logic [7:0] LIVE = 8'hC3;
  localparam logic [5:0] A_EN = 6'h2E;
  localparam logic [5:0] A_FL = 6'h2F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_i = 8'hFF;
  logic [7:0] pol_i = 8'hFF;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = 6'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcirq_unit uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .pol_i(pol_i),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Reference model built from the requirements
  logic [7:0] m_s1, m_s2, m_prev, m_en, m_flag;
  logic       m_irq;
  int         m_age;

  function automatic logic [7:0] edge_of(input logic [7:0] cur, input logic [7:0] old,
                                         input logic [7:0] pol);
    return ((cur & ~old & pol) | (~cur & old & ~pol)) & LIVE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 8'h00; m_s2 <= 8'h00; m_prev <= 8'h00;
      m_en <= 8'h00; m_flag <= 8'h00; m_irq <= 1'b0; m_age <= 0;
    end else begin
      logic [7:0] hitv, clr;
      hitv = (m_age >= 3) ? edge_of(m_s2, m_prev, pol_i) : 8'h00;
      clr  = (bus_sel && bus_wr && bus_addr == A_FL) ? (bus_wdata & LIVE) : 8'h00;
      m_s1 <= pins_i; m_s2 <= m_s1; m_prev <= m_s2;
      if (m_age < 3) m_age <= m_age + 1;
      if (bus_sel && bus_wr && bus_addr == A_EN) m_en <= bus_wdata & LIVE;
      m_flag <= (m_flag & ~clr) | hitv;
      m_irq  <= |(m_flag & m_en);
    end
  end

  function automatic logic [7:0] exp_read(input logic [5:0] a);
    if (a == A_EN) return m_en;
    if (a == A_FL) return m_flag;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rd(A_EN, v); chk("R1 enable in reset", v, 8'h00);
    rd(A_FL, v); chk("R1 flags in reset", v, 8'h00);
    chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    rd(A_FL, v); chk("R1 flags at release", v, 8'h00);
    repeat (5) tick();
    rd(A_FL, v); chk("R8 no flag from reset level", v, 8'h00);

    wr(A_EN, 8'hFF);
    rd(A_EN, v); chk("R2 R3 enable masked store", v, 8'hC3);
    rd(6'h10, v); chk("R2 unmapped address", v, 8'h00);
    rd(A_FL, v); chk("R3 enable write leaves flags", v, 8'h00);
    wr(A_EN, 8'h00);

    pins_i = 8'h00; repeat (4) tick();
    rd(A_FL, v); chk("R4 opposite edge ignored", v, 8'h00);
    pins_i = 8'hFF; tick(); tick();
    rd(A_FL, v); chk("R4 not yet after two edges", v, 8'h00);
    tick();
    rd(A_FL, v); chk("R4 R8 rising on live pins only", v, 8'hC3);
    tick();
    chk("R7 masked while disabled", {7'd0, irq_o}, 8'h00);

    wr(A_EN, 8'h01);
    chk("R7 irq not same edge", {7'd0, irq_o}, 8'h00);
    tick();
    chk("R7 irq one cycle later", {7'd0, irq_o}, 8'h01);

    wr(A_FL, 8'h00);
    rd(A_FL, v); chk("R5 zero write no effect", v, 8'hC3);
    wr(A_FL, 8'h3C);
    rd(A_FL, v); chk("R2 reserved clear ignored", v, 8'hC3);
    wr(A_FL, 8'h01);
    rd(A_FL, v); chk("R5 write one clears", v, 8'hC2);
    tick();
    chk("R7 irq drops after clear", {7'd0, irq_o}, 8'h00);

    wr(A_FL, 8'hFF);
    pol_i = 8'h7F; pins_i = 8'h7F; repeat (3) tick();
    rd(A_FL, v); chk("R4 falling edge with polarity 0", v, 8'h80);
    pins_i = 8'h3F; repeat (3) tick();
    rd(A_FL, v); chk("R4 falling ignored with polarity 1", v, 8'h80);

    wr(A_FL, 8'hFF);
    pol_i = 8'hFF; pins_i = 8'h7F; tick(); tick();
    wr(A_FL, 8'h40);
    rd(A_FL, v); chk("R6 set wins over clear", v, 8'h40);
    wr(A_FL, 8'h40);
    rd(A_FL, v); chk("R5 clear after collision", v, 8'h00);

    pins_i = 8'h7B; repeat (3) tick();
    pins_i = 8'h7F; repeat (3) tick();
    rd(A_FL, v); chk("R8 reserved pin toggle", v, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r;
      chk("R7 random irq", {7'd0, irq_o}, {7'd0, m_irq});
      r = 8'($urandom);
      if (($urandom % 3) == 0) pins_i = pins_i ^ (r & 8'($urandom));
      if (($urandom % 50) == 0) pol_i = 8'($urandom);
      case ($urandom % 4)
        0: bus_addr = A_EN;
        1: bus_addr = A_FL;
        2: bus_addr = A_FL;
        default: bus_addr = 6'($urandom);
      endcase
      bus_sel = (($urandom % 4) == 0);
      bus_wr = bus_sel && (($urandom % 2) == 0);
      bus_wdata = 8'($urandom);
      #1;
      chk("R2 R4 R5 random read", bus_rdata, exp_read(bus_addr));
      tick();
    end
    bus_sel = 1'b0; bus_wr = 1'b0;

    wr(A_EN, 8'hC3);
    rst_n = 1'b0; #1;
    rd(A_EN, v); chk("R1 enable cleared by reset", v, 8'h00);
    chk("R1 irq cleared by reset", {7'd0, irq_o}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule